// File: doc/BRIEF.md
# Offcore Request Latency Monitor

This block observes memory requests as they leave a processor core and the responses that later return for them. It keeps a small table of requests in flight, indexed by transaction ID, and drives two 48-bit event counters. Each counter has its own match setting made of five fields: a request-type mask, a supplier mask, a snoop mask, an any-response flag and an outstanding flag.

In normal mode the two counters are independent. Each one counts the returning responses whose request type, supplier and snoop result all pass its masks. In average-latency mode, counter 0 is set to the outstanding flag and a request-type mask. Every cycle it adds the number of matching requests then in flight. Counter 1 is set to the same request types with any-response and counts one per matching completion. Software divides counter 0 by counter 1 to get the mean latency in core cycles.

Top module: `ocr_lat_mon`

## Requirements
- R1: After reset both counters read zero, no request is in flight and, with an all-zero setting, `cfg_err` is 0.
- R2: In normal mode a counter advances by one, visible one clock after the response cycle, for a response of type `t` with supplier index `s` and snoop index `n` when bit `t` of its request mask, bit `s` of its supplier mask and bit `n` of its snoop mask are all set. If one of these bits is clear, it does not advance.
- R3: When a counter's any-response flag is set, every response whose type bit is set in its request mask is counted, whatever the supplier and snoop indices are.
- R4: A counter whose supplier and snoop masks are both zero behaves as if any-response were set.
- R5: In normal mode each counter follows only its own setting, and one response can advance either counter, both or neither.
- R6: In average-latency mode, when counter 0 has the outstanding flag set and a legal setting, it adds once per clock the number of in-flight requests whose type bit is set in its request mask. A request issued and a response retired in the same clock both count toward that clock's number.
- R7: Counter 1 advances by at most one per clock, once for each matching completion, in both modes.
- R8: `cfg_err[k]` is 1 while counter k has the outstanding flag set together with any supplier bit, snoop bit or the any-response flag. A counter with the outstanding flag set never counts responses, and an erroneous counter 0 does not integrate.
- R9: A response whose ID has no request in flight is ignored. A request whose ID is already in flight (and not retiring in that clock) is ignored and leaves the stored type unchanged.
- R10: `clr` sets both counters to zero at the next clock and takes priority over any increment in that clock.
- R11: A response whose type bit is clear in a counter's request mask never advances that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of both counters |
| avg_mode | input | 1 | 1 = average-latency mode, 0 = normal mode |
| c0_req_mask | input | 4 | Counter 0 request-type mask, bit i selects type i |
| c0_sup_mask | input | 4 | Counter 0 supplier mask, bit i selects supplier index i |
| c0_snp_mask | input | 4 | Counter 0 snoop mask, bit i selects snoop index i |
| c0_any | input | 1 | Counter 0 any-response flag |
| c0_outs | input | 1 | Counter 0 outstanding flag |
| c1_req_mask | input | 4 | Counter 1 request-type mask |
| c1_sup_mask | input | 4 | Counter 1 supplier mask |
| c1_snp_mask | input | 4 | Counter 1 snoop mask |
| c1_any | input | 1 | Counter 1 any-response flag |
| c1_outs | input | 1 | Counter 1 outstanding flag |
| req_valid | input | 1 | A request is issued this clock |
| req_id | input | 4 | Transaction ID of the request |
| req_type | input | 2 | Request type index |
| rsp_valid | input | 1 | A response returns this clock |
| rsp_id | input | 4 | Transaction ID of the response |
| rsp_sup | input | 2 | Supplier index of the response |
| rsp_snp | input | 2 | Snoop result index of the response |
| cnt0 | output | 48 | Counter 0 value |
| cnt1 | output | 48 | Counter 1 value |
| cfg_err | output | 2 | Per-counter illegal-setting flag |

## Verification
Every counter effect of a request, response or clear that is sampled at clock edge k shows on `cnt0`/`cnt1` right after edge k, because one register lies on the path. `cfg_err` follows the setting inputs within the same clock. The bench drives on the falling edge and reads on the next falling edge, so it checks each counter value half a clock after the edge that produced it. In the occupancy test this lets it check the running sum after every single clock, including the clock in which a request and a response share an edge.

// File: rtl/ocr_pkg.sv
// Shared constants and the per-counter match setting type for the
// offcore request latency monitor.
package ocr_pkg;
    localparam int TYPE_N = 4;                 // request types
    localparam int SUP_N  = 4;                 // supplier classes
    localparam int SNP_N  = 4;                 // snoop result classes
    localparam int TYPE_W = $clog2(TYPE_N);
    localparam int SUP_W  = $clog2(SUP_N);
    localparam int SNP_W  = $clog2(SNP_N);

    typedef struct packed {
        logic [TYPE_N-1:0] req;
        logic [SUP_N-1:0]  sup;
        logic [SNP_N-1:0]  snp;
        logic              any;
        logic              outs;
    } mcfg_t;
endpackage

// File: rtl/ocr_tracker.sv
// In-flight request table, one slot per transaction ID.
// Assumes IDs index slots directly. A response retires its slot in the clock it
// arrives. The occupancy count reflects the table after that clock's issue and
// retire have both been applied.
module ocr_tracker
    import ocr_pkg::*;
#(
    parameter int NUM_ID = 16,
    parameter int ID_W   = $clog2(NUM_ID),
    parameter int OCC_W  = $clog2(NUM_ID + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [TYPE_W-1:0] req_type,
    input  logic              rsp_valid,
    input  logic [ID_W-1:0]   rsp_id,
    input  logic [TYPE_N-1:0] occ_mask,
    output logic              rsp_hit,
    output logic [TYPE_W-1:0] rsp_type,
    output logic [OCC_W-1:0]  occ_cnt
);
    logic [NUM_ID-1:0] slot_v, set_v, ret_v, nxt_v;
    logic [TYPE_W-1:0] slot_t [NUM_ID];
    logic [TYPE_W-1:0] nxt_t  [NUM_ID];

    // Response lookup: hit only when the addressed slot holds a request.
    always_comb begin
        rsp_hit  = rsp_valid && slot_v[rsp_id];
        rsp_type = slot_t[rsp_id];
    end

    // Per-slot retire and accept decisions, and the resulting next state.
    always_comb begin
        ret_v = '0;
        set_v = '0;
        if (rsp_hit) ret_v[rsp_id] = 1'b1;
        if (req_valid && (!slot_v[req_id] || ret_v[req_id])) set_v[req_id] = 1'b1;
        nxt_v = (slot_v & ~ret_v) | set_v;
    end

    // Occupancy of matching types after this clock's issue and retire.
    always_comb begin
        occ_cnt = '0;
        for (int i = 0; i < NUM_ID; i++) begin
            nxt_t[i] = set_v[i] ? req_type : slot_t[i];
            if (nxt_v[i] && occ_mask[nxt_t[i]]) occ_cnt = occ_cnt + OCC_W'(1);
        end
    end

    // Slot valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_v <= '0;
        else        slot_v <= nxt_v;
    end

    // Slot type storage, written when a request is accepted.
    for (genvar g = 0; g < NUM_ID; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (set_v[g]) slot_t[g] <= req_type;
        end
    end

    // R9: an accepted request occupies its slot after the clock.
    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !slot_v[req_id]) |=> slot_v[$past(req_id)]);
    // R9: a retired slot is empty after the clock unless it is refilled.
    a_r9_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !(req_valid && req_id == rsp_id)) |=> !slot_v[$past(rsp_id)]);
endmodule

// File: rtl/ocr_match.sv
// Response match rule for one counter.
// Any-response, or an empty supplier and snoop setting, skips the supplier and
// snoop test. The outstanding flag turns response counting off.
module ocr_match
    import ocr_pkg::*;
(
    input  mcfg_t             cfg,
    input  logic              rsp_hit,
    input  logic [TYPE_W-1:0] rsp_type,
    input  logic [SUP_W-1:0]  rsp_sup,
    input  logic [SNP_W-1:0]  rsp_snp,
    output logic              hit,
    output logic              err
);
    logic eff_any;

    // Evaluate the match and the legality of the setting.
    always_comb begin
        eff_any = cfg.any || (cfg.sup == '0 && cfg.snp == '0);
        err     = cfg.outs && ((|cfg.sup) || (|cfg.snp) || cfg.any);
        hit     = rsp_hit && !cfg.outs && cfg.req[rsp_type] &&
                  (eff_any || (cfg.sup[rsp_sup] && cfg.snp[rsp_snp]));
    end
endmodule

// File: rtl/ocr_counter.sv
// Event accumulator with synchronous clear. The clear wins over the increment.
// Wraps modulo 2**CNT_W.
module ocr_counter #(
    parameter int CNT_W = 48,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    // Accumulate, clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + CNT_W'(inc);
    end
endmodule

// File: rtl/ocr_lat_mon.sv
// Offcore request latency monitor top level.
// Assumes at most one request and one response per clock, with IDs below NUM_ID.
// Counter 0 integrates occupancy in average-latency mode. Otherwise both
// counters count matching responses.
module ocr_lat_mon
    import ocr_pkg::*;
#(
    parameter int NUM_ID = 16,
    parameter int CNT_W  = 48,
    localparam int ID_W  = $clog2(NUM_ID),
    localparam int OCC_W = $clog2(NUM_ID + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              avg_mode,
    input  logic [TYPE_N-1:0] c0_req_mask,
    input  logic [SUP_N-1:0]  c0_sup_mask,
    input  logic [SNP_N-1:0]  c0_snp_mask,
    input  logic              c0_any,
    input  logic              c0_outs,
    input  logic [TYPE_N-1:0] c1_req_mask,
    input  logic [SUP_N-1:0]  c1_sup_mask,
    input  logic [SNP_N-1:0]  c1_snp_mask,
    input  logic              c1_any,
    input  logic              c1_outs,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [TYPE_W-1:0] req_type,
    input  logic              rsp_valid,
    input  logic [ID_W-1:0]   rsp_id,
    input  logic [SUP_W-1:0]  rsp_sup,
    input  logic [SNP_W-1:0]  rsp_snp,
    output logic [CNT_W-1:0]  cnt0,
    output logic [CNT_W-1:0]  cnt1,
    output logic [1:0]        cfg_err
);
    mcfg_t             cfg [2];
    logic [1:0]        hit;
    logic [OCC_W-1:0]  inc [2];
    logic [CNT_W-1:0]  cnt [2];
    logic              rsp_hit;
    logic [TYPE_W-1:0] rsp_type;
    logic [OCC_W-1:0]  occ_cnt;

    // Gather the per-counter settings into structs.
    always_comb begin
        cfg[0] = '{req: c0_req_mask, sup: c0_sup_mask, snp: c0_snp_mask, any: c0_any, outs: c0_outs};
        cfg[1] = '{req: c1_req_mask, sup: c1_sup_mask, snp: c1_snp_mask, any: c1_any, outs: c1_outs};
    end

    ocr_tracker #(.NUM_ID(NUM_ID)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_id(req_id), .req_type(req_type),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .occ_mask(c0_req_mask),
        .rsp_hit(rsp_hit), .rsp_type(rsp_type), .occ_cnt(occ_cnt)
    );

    for (genvar k = 0; k < 2; k++) begin : g_ctr
        ocr_match u_match (
            .cfg(cfg[k]), .rsp_hit(rsp_hit), .rsp_type(rsp_type),
            .rsp_sup(rsp_sup), .rsp_snp(rsp_snp),
            .hit(hit[k]), .err(cfg_err[k])
        );
        ocr_counter #(.CNT_W(CNT_W), .INC_W(OCC_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc[k]), .cnt(cnt[k])
        );
    end

    // Choose each counter's increment: occupancy or response hits.
    always_comb begin
        if (avg_mode) inc[0] = (c0_outs && !cfg_err[0]) ? occ_cnt : '0;
        else          inc[0] = OCC_W'(hit[0]);
        inc[1] = OCC_W'(hit[1]);
        cnt0   = cnt[0];
        cnt1   = cnt[1];
    end

    // R10: clear leaves both counters at zero.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt0 == '0 && cnt1 == '0));
    // R7: counter 1 advances by at most one per clock.
    a_r7_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt1 - $past(cnt1)) <= CNT_W'(1));
    // R8: an erroneous counter 0 holds its value.
    a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err[0] && !clr) |=> $stable(cnt0));
    // R2: in normal mode counter 0 moves only on a response.
    a_r2_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (!avg_mode && !rsp_valid && !clr) |=> $stable(cnt0));
endmodule

// File: tb/sim_ocr_lat_mon.sv
module sim_ocr_lat_mon;
    import ocr_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // {req[4], sup[4], snp[4], any, type[2], sup_idx[2], snp_idx[2], exp}
    localparam logic [19:0] VEC [NV] = '{
        {4'b0001, 4'b0010, 4'b0100, 1'b0, 2'd0, 2'd1, 2'd2, 1'b1},  // R2 all match
        {4'b0001, 4'b0010, 4'b0100, 1'b0, 2'd0, 2'd0, 2'd2, 1'b0},  // R2 supplier miss
        {4'b0001, 4'b0010, 4'b0100, 1'b0, 2'd0, 2'd1, 2'd3, 1'b0},  // R2 snoop miss
        {4'b0001, 4'b0010, 4'b0100, 1'b0, 2'd1, 2'd1, 2'd2, 1'b0},  // R11 type miss
        {4'b1111, 4'b0001, 4'b0001, 1'b1, 2'd2, 2'd3, 2'd3, 1'b1},  // R3 override
        {4'b0100, 4'b0000, 4'b0000, 1'b0, 2'd2, 2'd2, 2'd1, 1'b1},  // R4 empty masks
        {4'b0100, 4'b0000, 4'b0000, 1'b0, 2'd3, 2'd0, 2'd0, 1'b0},  // R11 type miss
        {4'b1000, 4'b1000, 4'b0000, 1'b0, 2'd3, 2'd3, 2'd0, 1'b0}   // R2 snoop mask empty
    };

    logic clk = 0, rst_n = 0, clr = 0, avg_mode = 0;
    logic [3:0] c0_req = 0, c0_sup = 0, c0_snp = 0, c1_req = 0, c1_sup = 0, c1_snp = 0;
    logic c0_any = 0, c0_outs = 0, c1_any = 0, c1_outs = 0;
    logic req_valid = 0, rsp_valid = 0;
    logic [3:0] req_id = 0, rsp_id = 0;
    logic [1:0] req_type = 0, rsp_sup = 0, rsp_snp = 0;
    logic [47:0] cnt0, cnt1;
    logic [1:0] cfg_err;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocr_lat_mon u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .avg_mode(avg_mode),
        .c0_req_mask(c0_req), .c0_sup_mask(c0_sup), .c0_snp_mask(c0_snp), .c0_any(c0_any), .c0_outs(c0_outs),
        .c1_req_mask(c1_req), .c1_sup_mask(c1_sup), .c1_snp_mask(c1_snp), .c1_any(c1_any), .c1_outs(c1_outs),
        .req_valid(req_valid), .req_id(req_id), .req_type(req_type),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_sup(rsp_sup), .rsp_snp(rsp_snp),
        .cnt0(cnt0), .cnt1(cnt1), .cfg_err(cfg_err)
    );

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(logic [3:0] id, logic [1:0] t);
        req_valid = 1; req_id = id; req_type = t; cyc(); req_valid = 0;
    endtask

    task automatic respond(logic [3:0] id, logic [1:0] s, logic [1:0] n);
        rsp_valid = 1; rsp_id = id; rsp_sup = s; rsp_snp = n; cyc(); rsp_valid = 0;
    endtask

    task automatic clear();
        clr = 1; cyc(); clr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); cyc(); cyc();
        rst_n = 1; cyc();
        // R1 reset state
        chk("R1 cnt0", cnt0, 0);
        chk("R1 cnt1", cnt1, 0);
        chk("R1 cfg_err", 48'(cfg_err), 0);

        // Table walk: normal-mode match rules on counter 0
        for (int v = 0; v < NV; v++) begin
            logic [19:0] e;
            e = VEC[v];
            c0_req = e[19:16]; c0_sup = e[15:12]; c0_snp = e[11:8]; c0_any = e[7];
            clear();
            issue(4'd3, e[6:5]);
            respond(4'd3, e[4:3], e[2:1]);
            chk($sformatf("R2/R3/R4/R11 vector %0d cnt0", v), cnt0, 48'(e[0]));
            chk($sformatf("R5 vector %0d cnt1", v), cnt1, 0);
        end

        // R5 independent counters
        c0_req = 4'b0001; c0_sup = 0; c0_snp = 0; c0_any = 1;
        c1_req = 4'b0010; c1_any = 1;
        clear();
        issue(4'd1, 2'd0); issue(4'd2, 2'd1);
        respond(4'd1, 2'd0, 2'd0);
        chk("R5 cnt0 after type0", cnt0, 1);
        chk("R5 cnt1 after type0", cnt1, 0);
        respond(4'd2, 2'd0, 2'd0);
        chk("R5 cnt0 after type1", cnt0, 1);
        chk("R5 cnt1 after type1", cnt1, 1);

        // R9 unknown response and duplicate request
        c1_req = 0; c1_any = 0;
        clear();
        respond(4'd5, 2'd0, 2'd0);
        chk("R9 stray response", cnt0, 0);
        issue(4'd5, 2'd0); issue(4'd5, 2'd1);
        respond(4'd5, 2'd0, 2'd0);
        chk("R9 duplicate kept first type", cnt0, 1);
        respond(4'd5, 2'd0, 2'd0);
        chk("R9 second response ignored", cnt0, 1);

        // R6 / R7 average-latency mode
        avg_mode = 1;
        c0_req = 4'b0011; c0_any = 0; c0_outs = 1;
        c1_req = 4'b0011; c1_any = 1;
        clear();
        issue(4'd0, 2'd0);            chk("R6 occ 1", cnt0, 1);
        issue(4'd1, 2'd1);            chk("R6 occ 2", cnt0, 3);
        issue(4'd2, 2'd2);            chk("R6 unmatched type", cnt0, 5);
        req_valid = 1; req_id = 4'd3; req_type = 2'd0;
        respond(4'd0, 2'd0, 2'd0); req_valid = 0;
        chk("R6 same-clock issue and retire", cnt0, 7);
        chk("R7 first completion", cnt1, 1);
        cyc();                        chk("R6 idle clock", cnt0, 9);
        respond(4'd1, 2'd0, 2'd0);    chk("R6 after retire", cnt0, 10);
        chk("R7 second completion", cnt1, 2);
        respond(4'd2, 2'd0, 2'd0);    chk("R7 unmatched completion", cnt1, 2);
        respond(4'd3, 2'd0, 2'd0);    chk("R6 last retire", cnt0, 11);
        chk("R7 third completion", cnt1, 3);

        // R8 illegal outstanding setting
        c0_any = 1;
        clear();
        issue(4'd6, 2'd0);
        chk("R8 cfg_err", 48'(cfg_err), 1);
        cyc();
        chk("R8 no integration", cnt0, 0);
        c0_any = 0; cyc();
        chk("R8 error cleared", 48'(cfg_err), 0);
        chk("R8 legal integrates", cnt0, 1);
        respond(4'd6, 2'd0, 2'd0);

        // R10 clear wins over a same-clock increment
        avg_mode = 0; c0_outs = 0; c0_req = 4'b1111; c0_any = 1;
        issue(4'd7, 2'd0);
        clr = 1; respond(4'd7, 2'd0, 2'd0); clr = 0;
        chk("R10 cnt0 cleared", cnt0, 0);
        chk("R10 cnt1 cleared", cnt1, 0);
        issue(4'd8, 2'd1); respond(4'd8, 2'd0, 2'd0);
        chk("R10 counts after clear", cnt0, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule